// File: doc/BRIEF.md
# Display and Board Control Register

This block is a single 32-bit read/write control word on a simple memory-mapped bus. It sits at byte offset 0x0C in a window of word-spaced registers. Its stored bits drive board-level signals directly: the status LED, the boot memory selection at address 0, flash write permission, two display enables, two axis-flip selects, an auxiliary panel line, the video colour-depth select and the bias supply enable. A three-bit field picks one of three display paths, or none.

Two bits step an LCD bias supply. When software writes a word that takes one of these bits from 0 to 1, the block emits a one-cycle step pulse. The block also tracks a saturating bias level so that the steps can be observed. A write-one bit requests a one-cycle system reset pulse, and that bit always reads back as zero. Bit 1 is read-only and shows the board-presence input. Reserved bits keep whatever is written to them, so software can safely use read-modify-write.

Top module: `disp_ctrl_reg`

## Requirements
- R1: Only a bus access whose byte address equals 0x0C reaches the register. A write at any other address leaves every stored bit and output unchanged. A read at any other address returns 0. Read data is combinational on the access cycle.
- R2: After reset, every stored bit is 0, every output pulse is low, all path selects are low, and the bias level is 32.
- R3: Bits [31:21] and [7:4] read back exactly as last written.
- R4: Writing 1 to bit 3 raises sys_rst_pulse for exactly the one cycle that follows the write edge. Bit 3 always reads as 0.
- R5: Bit 1 of the read data equals the board_absent input during the read (0 = on baseboard, 1 = none). Writes to bit 1 have no effect.
- R6: A write in which bit 9 goes from stored 0 to written 1 raises bias_up_pulse for one cycle and increments bias_level at the same edge. The step only happens when the written word also has bit 8 = 1 and bit 19 = 1. The level saturates at 63.
- R7: Under the same gating, a 0-to-1 write on bit 10 raises bias_dn_pulse for one cycle and decrements bias_level. The level saturates at 0.
- R8: No step pulse is issued and the level is unchanged in three cases: the written bit 8 is 0, the written bit 19 is 0, or the stored step bit was already 1.
- R9: Bits [13:11] select the display path: 001 selects path_generic, 011 or 100 selects path_panel, 111 selects path_vga, and any other code selects none. At most one path select is high.
- R10: Stored bits drive outputs directly, with the new value visible the cycle after the write: bit 0 led, bit 2 boot_sram, bit 8 bias_en, bit 14 lcd_en0, bit 15 lcd_en1, bit 16 flip_h, bit 17 flip_v, bit 18 panel_aux, bit 19 depth_18b (1 = 18-bit), bit 20 flash_wr_en (1 = writable).
- R11: A single write that raises both bit 9 and bit 10 under valid gating issues both pulses and leaves the bias level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| board_absent | input | 1 | 1 = no baseboard present |
| led | output | 1 | Status LED |
| boot_sram | output | 1 | 1 = SRAM at address 0, 0 = flash |
| bias_en | output | 1 | Bias supply enable |
| lcd_en0 | output | 1 | Display enable 0 |
| lcd_en1 | output | 1 | Display enable 1 |
| flip_h | output | 1 | Horizontal axis flip |
| flip_v | output | 1 | Vertical axis flip |
| panel_aux | output | 1 | Auxiliary panel line |
| depth_18b | output | 1 | 1 = 18-bit video depth, 0 = 24-bit |
| flash_wr_en | output | 1 | Flash write permission |
| path_generic | output | 1 | Generic 24-bit connector selected |
| path_panel | output | 1 | Flat-panel path selected |
| path_vga | output | 1 | 24-bit VGA path selected |
| bias_up_pulse | output | 1 | One-cycle bias increase step |
| bias_dn_pulse | output | 1 | One-cycle bias decrease step |
| bias_level | output | 6 | Saturating bias level |
| sys_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
Read data is combinational, so it is due in the same cycle as the read strobe. Stored-bit outputs, path selects, both step pulses, the bias level and the reset pulse are all due one clock edge after the write. The bench drives each access at a falling edge, checks read data a moment later in that same low phase, and advances its reference model to the state after the coming rising edge. It then checks every registered output at the next falling edge, so each result is sampled exactly one edge after its cause. The internal reset takes two extra edges to release, so the bench issues only idle cycles during that time.

// File: rtl/disp_ctrl_pkg.sv
package disp_ctrl_pkg;
  localparam int DATA_W = 32;

  localparam int B_LED   = 0;
  localparam int B_PRES  = 1;
  localparam int B_BOOT  = 2;
  localparam int B_RST   = 3;
  localparam int B_BEN   = 8;
  localparam int B_UP    = 9;
  localparam int B_DN    = 10;
  localparam int B_PATH  = 11;
  localparam int B_EN0   = 14;
  localparam int B_EN1   = 15;
  localparam int B_FH    = 16;
  localparam int B_FV    = 17;
  localparam int B_AUX   = 18;
  localparam int B_DEPTH = 19;
  localparam int B_FLASH = 20;

  // Bits that never hold state: the reset request and the presence input.
  localparam logic [DATA_W-1:0] STORE_MASK =
    ~((DATA_W'(1) << B_RST) | (DATA_W'(1) << B_PRES));

  typedef enum logic [1:0] {
    PATH_NONE,
    PATH_GENERIC,
    PATH_PANEL,
    PATH_VGA
  } path_e;

  function automatic path_e path_of(input logic [2:0] code);
    case (code)
      3'b001:          return PATH_GENERIC;
      3'b011, 3'b100:  return PATH_PANEL;
      3'b111:          return PATH_VGA;
      default:         return PATH_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rst_sync.sv
module rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/reg_decode.sv
module reg_decode #(
  parameter int              ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h0C
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic addr_match;

  always_comb begin
    addr_match = (addr == REG_OFFSET);
    wr_hit     = sel && wr && addr_match;
    rd_hit     = sel && !wr && addr_match;
  end
endmodule

// File: rtl/ctrl_store.sv
module ctrl_store
  import disp_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              rst_pulse
);
  logic [DATA_W-1:0] ctrl_d;
  logic              ctrl_en;
  logic              rst_pulse_d;

  always_comb begin
    ctrl_en     = wr_hit;
    ctrl_d      = wdata & STORE_MASK;
    rst_pulse_d = wr_hit && wdata[B_RST];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_en) begin
      ctrl_q <= ctrl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pulse <= 1'b0;
    else        rst_pulse <= rst_pulse_d;
  end

  assert_hold_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(ctrl_q));

  assert_rst_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> $past(wr_hit && wdata[B_RST]));
endmodule

// File: rtl/bias_step.sv
module bias_step #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic             new_up,
  input  logic             new_dn,
  input  logic             new_ben,
  input  logic             new_depth,
  input  logic             old_up,
  input  logic             old_dn,
  output logic             up_pulse,
  output logic             dn_pulse,
  output logic [LVL_W-1:0] level
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;
  localparam logic [LVL_W-1:0] LVL_MIN = '0;
  localparam logic [LVL_W-1:0] LVL_MID = {1'b1, {(LVL_W-1){1'b0}}};

  logic             gate_ok;
  logic             up_d;
  logic             dn_d;
  logic [LVL_W-1:0] level_d;
  logic             level_en;

  always_comb begin
    gate_ok  = wr_hit && new_ben && new_depth;
    up_d     = gate_ok && new_up && !old_up;
    dn_d     = gate_ok && new_dn && !old_dn;
    level_en = 1'b0;
    level_d  = level;
    if (up_d && !dn_d && level != LVL_MAX) begin
      level_en = 1'b1;
      level_d  = level + 1'b1;
    end else if (dn_d && !up_d && level != LVL_MIN) begin
      level_en = 1'b1;
      level_d  = level - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_pulse <= 1'b0;
      dn_pulse <= 1'b0;
    end else begin
      up_pulse <= up_d;
      dn_pulse <= dn_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        level <= LVL_MID;
    else if (level_en) level <= level_d;
  end

  assert_up_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_pulse && !dn_pulse) |->
      ((level == $past(level) + 1'b1) || ($past(level) == LVL_MAX && level == LVL_MAX)));

  assert_dn_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_pulse && !up_pulse) |->
      ((level == $past(level) - 1'b1) || ($past(level) == LVL_MIN && level == LVL_MIN)));

  assert_level_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (up_pulse == dn_pulse) |-> $stable(level));
endmodule

// File: rtl/disp_ctrl_reg.sv
module disp_ctrl_reg
  import disp_ctrl_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h0C,
  parameter int                LVL_W      = 6,
  parameter int                SYNC_STG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              board_absent,
  output logic              led,
  output logic              boot_sram,
  output logic              bias_en,
  output logic              lcd_en0,
  output logic              lcd_en1,
  output logic              flip_h,
  output logic              flip_v,
  output logic              panel_aux,
  output logic              depth_18b,
  output logic              flash_wr_en,
  output logic              path_generic,
  output logic              path_panel,
  output logic              path_vga,
  output logic              bias_up_pulse,
  output logic              bias_dn_pulse,
  output logic [LVL_W-1:0]  bias_level,
  output logic              sys_rst_pulse
);
  logic              rst_i_n;
  logic              wr_hit;
  logic              rd_hit;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] readback;
  path_e             path_sel;

  rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_i_n)
  );

  reg_decode #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_decode (
    .sel    (bus_sel),
    .wr     (bus_wr),
    .addr   (bus_addr),
    .wr_hit (wr_hit),
    .rd_hit (rd_hit)
  );

  ctrl_store u_store (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_hit    (wr_hit),
    .wdata     (bus_wdata),
    .ctrl_q    (ctrl_q),
    .rst_pulse (sys_rst_pulse)
  );

  bias_step #(.LVL_W(LVL_W)) u_bias (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .wr_hit    (wr_hit),
    .new_up    (bus_wdata[B_UP]),
    .new_dn    (bus_wdata[B_DN]),
    .new_ben   (bus_wdata[B_BEN]),
    .new_depth (bus_wdata[B_DEPTH]),
    .old_up    (ctrl_q[B_UP]),
    .old_dn    (ctrl_q[B_DN]),
    .up_pulse  (bias_up_pulse),
    .dn_pulse  (bias_dn_pulse),
    .level     (bias_level)
  );

  always_comb begin
    readback         = ctrl_q;
    readback[B_RST]  = 1'b0;
    readback[B_PRES] = board_absent;
    bus_rdata        = rd_hit ? readback : '0;
  end

  always_comb begin
    led         = ctrl_q[B_LED];
    boot_sram   = ctrl_q[B_BOOT];
    bias_en     = ctrl_q[B_BEN];
    lcd_en0     = ctrl_q[B_EN0];
    lcd_en1     = ctrl_q[B_EN1];
    flip_h      = ctrl_q[B_FH];
    flip_v      = ctrl_q[B_FV];
    panel_aux   = ctrl_q[B_AUX];
    depth_18b   = ctrl_q[B_DEPTH];
    flash_wr_en = ctrl_q[B_FLASH];
  end

  always_comb begin
    path_sel     = path_of(ctrl_q[B_PATH +: 3]);
    path_generic = (path_sel == PATH_GENERIC);
    path_panel   = (path_sel == PATH_PANEL);
    path_vga     = (path_sel == PATH_VGA);
  end

  assert_path_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    $onehot0({path_generic, path_panel, path_vga}));

  assert_rst_reads_zero_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_rdata[B_RST] == 1'b0);

  assert_step_gated_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bias_up_pulse || bias_dn_pulse) |-> (bias_en && depth_18b));

  assert_presence_live_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_hit |-> (bus_rdata[B_PRES] == board_absent));
endmodule

// File: tb/disp_ctrl_reg_tb.sv
module disp_ctrl_reg_tb;
  localparam int CLK_P = 10;
  localparam logic [7:0] OFS = 8'h0C;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        board_absent;
  logic led, boot_sram, bias_en, lcd_en0, lcd_en1, flip_h, flip_v, panel_aux;
  logic depth_18b, flash_wr_en, path_generic, path_panel, path_vga;
  logic bias_up_pulse, bias_dn_pulse, sys_rst_pulse;
  logic [5:0]  bias_level;

  int n_cmp;
  int n_bad;

  // reference model state
  logic [31:0] m_ctrl;
  int          m_lvl;
  logic        m_up, m_dn, m_rst;
  string       scen;

  disp_ctrl_reg u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .board_absent(board_absent), .led(led), .boot_sram(boot_sram),
    .bias_en(bias_en), .lcd_en0(lcd_en0), .lcd_en1(lcd_en1),
    .flip_h(flip_h), .flip_v(flip_v), .panel_aux(panel_aux),
    .depth_18b(depth_18b), .flash_wr_en(flash_wr_en),
    .path_generic(path_generic), .path_panel(path_panel), .path_vga(path_vga),
    .bias_up_pulse(bias_up_pulse), .bias_dn_pulse(bias_dn_pulse),
    .bias_level(bias_level), .sys_rst_pulse(sys_rst_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual %h expected %h", tag, scen, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_path(input logic [2:0] c);
    if (c == 3'b001) return 3'b001;
    if (c == 3'b011 || c == 3'b100) return 3'b010;
    if (c == 3'b111) return 3'b100;
    return 3'b000;
  endfunction

  task automatic check_regs();
    chk("R10 direct outputs",
        {22'd0, flash_wr_en, depth_18b, panel_aux, flip_v, flip_h, lcd_en1, lcd_en0,
         bias_en, boot_sram, led},
        {22'd0, m_ctrl[20], m_ctrl[19], m_ctrl[18], m_ctrl[17], m_ctrl[16], m_ctrl[15],
         m_ctrl[14], m_ctrl[8], m_ctrl[2], m_ctrl[0]});
    chk("R9 path select", {29'd0, path_vga, path_panel, path_generic},
        {29'd0, exp_path(m_ctrl[13:11])});
    chk("R6 up pulse", {31'd0, bias_up_pulse}, {31'd0, m_up});
    chk("R7 down pulse", {31'd0, bias_dn_pulse}, {31'd0, m_dn});
    chk("R6 R7 bias level", {26'd0, bias_level}, 32'(m_lvl));
    chk("R4 reset pulse", {31'd0, sys_rst_pulse}, {31'd0, m_rst});
  endtask

  task automatic step(input logic s, input logic w, input logic [7:0] a,
                      input logic [31:0] d, input logic absent);
    logic [31:0] exp_rd;
    logic [31:0] nv;
    logic        gate, up, dn;
    @(negedge clk);
    check_regs();
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; board_absent = absent;
    #1;
    exp_rd = (s && !w && a == OFS) ? ((m_ctrl & ~32'h0000_000A) | {30'd0, absent, 1'b0}) : 32'd0;
    chk("R1 R3 R5 read data", bus_rdata, exp_rd);
    if (s && w && a == OFS) begin
      nv   = d & ~32'h0000_000A;
      gate = d[8] && d[19];
      up   = gate && d[9] && !m_ctrl[9];
      dn   = gate && d[10] && !m_ctrl[10];
      if (up && !dn && m_lvl < 63) m_lvl++;
      if (dn && !up && m_lvl > 0)  m_lvl--;
      m_up = up; m_dn = dn; m_rst = d[3];
      m_ctrl = nv;
    end else begin
      m_up = 1'b0; m_dn = 1'b0; m_rst = 1'b0;
    end
  endtask

  task automatic wr(input logic [31:0] d);
    step(1'b1, 1'b1, OFS, d, board_absent);
  endtask

  task automatic rd();
    step(1'b1, 1'b0, OFS, 32'd0, board_absent);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 8'h00, 32'd0, board_absent);
  endtask

  localparam logic [31:0] GATE = (32'h1 << 19) | (32'h1 << 8);
  localparam logic [31:0] UPB  = 32'h1 << 9;
  localparam logic [31:0] DNB  = 32'h1 << 10;

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    m_ctrl = '0; m_lvl = 32; m_up = 0; m_dn = 0; m_rst = 0;
    scen = "reset";
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0; board_absent = 0;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk("R2 level at reset", {26'd0, bias_level}, 32'd32);
    chk("R2 pulses at reset", {29'd0, bias_up_pulse, bias_dn_pulse, sys_rst_pulse}, 32'd0);
    chk("R2 outputs at reset", {19'd0, led, boot_sram, bias_en, lcd_en0, lcd_en1, flip_h,
        flip_v, panel_aux, depth_18b, flash_wr_en, path_generic, path_panel, path_vga}, 32'd0);
    rst_n = 1'b1;
    repeat (4) idle();

    scen = "R3 R10 patterns";
    wr(32'hA5A5_5A5A); rd(); wr(32'h5A5A_A5A5); rd();
    wr(32'hFFFF_FFFF); rd(); wr(32'hFFE0_00F0); rd(); wr(32'h0000_0000); rd();

    scen = "R5 presence";
    step(1'b1, 1'b0, OFS, 32'd0, 1'b1);
    chk("R5 presence bit high", {31'd0, bus_rdata[1]}, 32'd1);
    step(1'b1, 1'b0, OFS, 32'd0, 1'b0);
    wr(32'h0000_0002); rd();

    scen = "R1 decode";
    wr(32'h0010_4005);
    step(1'b1, 1'b1, 8'h08, 32'hFFFF_FFFF, 1'b0);
    step(1'b1, 1'b1, 8'h10, 32'hFFFF_FFFF, 1'b0);
    step(1'b1, 1'b1, 8'h0D, 32'hFFFF_FFFF, 1'b0);
    step(1'b0, 1'b1, OFS, 32'hFFFF_FFFF, 1'b0);
    step(1'b1, 1'b0, 8'h00, 32'd0, 1'b1);
    step(1'b1, 1'b0, 8'h0C, 32'd0, 1'b1);
    chk("R1 stored word after stray writes", bus_rdata, 32'h0010_4007);

    scen = "R4 reset request";
    wr(32'h0000_0008); rd(); idle();
    wr(32'h0000_0009); wr(32'h0000_0009); rd(); idle(); idle();

    scen = "R9 path codes";
    for (int c = 0; c < 8; c++) begin
      wr(32'(c) << 11); rd();
    end

    scen = "R6 up saturation";
    for (int i = 0; i < 34; i++) begin
      wr(GATE); wr(GATE | UPB);
    end
    idle();
    chk("R6 saturated high", {26'd0, bias_level}, 32'd63);

    scen = "R7 down saturation";
    for (int i = 0; i < 66; i++) begin
      wr(GATE); wr(GATE | DNB);
    end
    idle();
    chk("R7 saturated low", {26'd0, bias_level}, 32'd0);
    for (int i = 0; i < 3; i++) begin
      wr(GATE); wr(GATE | UPB);
    end

    scen = "R8 gating";
    wr(32'h0); wr(UPB | (32'h1 << 8));
    wr(32'h0); wr(UPB | (32'h1 << 19));
    wr(32'h0); wr(DNB | (32'h1 << 8));
    wr(GATE | UPB); wr(GATE | UPB); idle();
    chk("R8 no step when already set", {31'd0, bias_up_pulse}, 32'd0);
    wr(GATE); wr(GATE | DNB); wr(GATE | DNB); idle();

    scen = "R11 both edges";
    wr(GATE); wr(GATE | UPB | DNB); idle();
    chk("R11 level unchanged", {26'd0, bias_level}, 32'(m_lvl));
    wr(GATE); wr(GATE | UPB | DNB | 32'h8); idle(); rd();

    repeat (3) idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule